// File: doc/BRIEF.md
# Dual-Path Digital Video Gain Control

This block scales two streams of digitized video samples, one luma and one chroma, by a per-path gain after the converter. Each 9-bit unsigned sample is multiplied by a 12-bit unsigned gain in Q2.10 form, rounded to nearest and clamped to the 9-bit output range. A flag marks every sample that had to be clamped. A shared strobe qualifies the samples, and results appear one clock after the sample.

Each path keeps one gain register. In manual mode a write strobe loads that register. In automatic mode a small loop measures the largest output over a window of valid samples and moves the gain by one step toward a target. The chroma path has a third choice: it borrows the luma gain. A freeze input stops the automatic loops. Each path's readback always shows the gain that is acting on its samples. On a mode change the register keeps its value, so the new mode starts from the old gain.

Top module: `vid_gain_ctrl`

## Requirements
- R1: While reset is asserted, both gain readbacks equal 0x400 (unity), out_valid is 0, both outputs are 0 and both clip flags are 0.
- R2: A sample taken with smp_valid high gives out = min(511, (in*gain + 512) >> 10) on the next clock, with out_valid high. When smp_valid is low, out_valid is low and the outputs keep their last values.
- R3: A clip flag is high for exactly the output cycle whose rounded product exceeded 511. An output carrying the flag equals 511.
- R4: The luma and chroma gains are independent. A chroma write, chroma mode or chroma loop never changes the luma gain.
- R5: A write strobe loads gain_wdata into its path's gain when that path is in manual mode (luma_mode 0, chroma_mode 2'b00). The new gain applies from the next sample. A write is ignored in automatic or follow mode.
- R6: In automatic mode (luma_mode 1, chroma_mode 2'b01), the loop counts WIN_LEN valid samples and tracks their largest clamped output. On the last sample of the window the gain drops by 1 if that peak is above the target. It rises by 1 if peak + HYST is below the target. Otherwise it holds. The gain never changes between window ends.
- R7: The automatic loop never steps the gain below GAIN_MIN (0x100) or above GAIN_MAX (0xFFF).
- R8: With chroma_mode 2'b10 or 2'b11, chroma samples use the luma gain and the chroma readback shows it. On leaving follow mode the chroma gain keeps that value.
- R9: While freeze is high, the automatic gains hold. After freeze falls, a new full window is measured before the next step.
- R10: Each readback port equals the gain applied to that path's current sample.
- R11: A mode change keeps the gain value. Going from manual to automatic starts the loop from the manual gain, with a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Both input samples are valid this cycle |
| luma_in | input | 9 | Luma sample |
| chroma_in | input | 9 | Chroma sample |
| luma_mode | input | 1 | 0 manual, 1 automatic |
| chroma_mode | input | 2 | 00 manual, 01 automatic, 1x follow luma |
| freeze | input | 1 | Hold both automatic loops |
| luma_gain_wr | input | 1 | Write strobe for the luma gain |
| chroma_gain_wr | input | 1 | Write strobe for the chroma gain |
| gain_wdata | input | 12 | Gain value to write, Q2.10 |
| luma_target | input | 9 | Peak target for the luma loop |
| chroma_target | input | 9 | Peak target for the chroma loop |
| out_valid | output | 1 | Outputs carry a new sample |
| luma_out | output | 9 | Scaled luma sample |
| chroma_out | output | 9 | Scaled chroma sample |
| luma_clip | output | 1 | Luma sample was clamped |
| chroma_clip | output | 1 | Chroma sample was clamped |
| luma_gain_rd | output | 12 | Luma gain in effect |
| chroma_gain_rd | output | 12 | Chroma gain in effect |

## Verification
A window end and a control event can land on the same clock edge. The control event can be a freeze, a mode change or a write. A saturating sample can also be the one that sets the window peak. The bench provokes these collisions with long stretches of random strobes, writes, freeze toggles and mode changes. A behavioural model applies the rules of R5, R6, R9 and R11 in their stated priority and predicts every output and readback on every clock. Directed runs with exact expected gains pin down the window length, the restart after freeze and the limit cases.

// File: rtl/vg_pkg.sv
package vg_pkg;

  // chroma path mode selection, encoded as on the chroma_mode port
  typedef enum logic [1:0] {
    CM_MANUAL  = 2'b00,
    CM_AUTO    = 2'b01,
    CM_FOLLOW  = 2'b10,
    CM_FOLLOW2 = 2'b11
  } chroma_mode_e;

  // outcome of one loop decision
  typedef struct packed {
    logic up;
    logic dn;
  } step_t;

endpackage

// File: rtl/vg_mult.sv
module vg_mult #(
  parameter int SAMP_W = 9,
  parameter int GAIN_W = 12,
  parameter int FRAC_W = 10
) (
  input  logic [SAMP_W-1:0] x,
  input  logic [GAIN_W-1:0] g,
  output logic [SAMP_W-1:0] y,
  output logic              clip
);
  localparam int PROD_W = SAMP_W + GAIN_W + 1;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic [PROD_W-1:0] YMAX = PROD_W'({SAMP_W{1'b1}});

  // rounded fixed-point product before clamping
  function automatic logic [PROD_W-1:0] scale(input logic [SAMP_W-1:0] a,
                                              input logic [GAIN_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = PROD_W'(a) * PROD_W'(b) + HALF;
    return p >> FRAC_W;
  endfunction

  logic [PROD_W-1:0] scaled;

  always_comb begin
    scaled = scale(x, g);
    clip   = (scaled > YMAX);
    y      = clip ? {SAMP_W{1'b1}} : scaled[SAMP_W-1:0];
  end
endmodule

// File: rtl/vg_agc_path.sv
module vg_agc_path
  import vg_pkg::*;
#(
  parameter int SAMP_W   = 9,
  parameter int GAIN_W   = 12,
  parameter int WIN_LEN  = 1024,
  parameter int GAIN_MIN = 256,
  parameter int GAIN_MAX = 4095,
  parameter int GAIN_RST = 1024,
  parameter int HYST     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              manual_en,
  input  logic              auto_en,
  input  logic              follow_en,
  input  logic              freeze,
  input  logic [GAIN_W-1:0] follow_val,
  input  logic              wr_en,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic              smp_valid,
  input  logic [SAMP_W-1:0] y_now,
  input  logic [SAMP_W-1:0] target,
  output logic [GAIN_W-1:0] gain_q,
  output logic [GAIN_W-1:0] gain_d,
  output logic              win_end
);
  localparam int CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_LEN - 1);
  localparam int CMP_W = SAMP_W + 2;

  // loop decision from window peak, target and present gain
  function automatic step_t decide(input logic [SAMP_W-1:0] pk,
                                   input logic [SAMP_W-1:0] tgt,
                                   input logic [GAIN_W-1:0] g);
    step_t s;
    logic [CMP_W-1:0] pk_h;
    pk_h = CMP_W'(pk) + CMP_W'(HYST);
    s.dn = (pk > tgt) && (g > GAIN_W'(GAIN_MIN));
    s.up = (pk_h < CMP_W'(tgt)) && (g < GAIN_W'(GAIN_MAX));
    return s;
  endfunction

  logic              run;
  logic [CNT_W-1:0]  cnt_q;
  logic [SAMP_W-1:0] peak_q;
  logic [SAMP_W-1:0] peak_now;
  step_t             step_now;

  assign run      = auto_en & ~freeze;
  assign win_end  = run & smp_valid & (cnt_q == CNT_LAST);
  assign peak_now = (y_now > peak_q) ? y_now : peak_q;
  assign step_now = decide(peak_now, target, gain_q);

  always_comb begin
    if (follow_en)                      gain_d = follow_val;
    else if (manual_en && wr_en)        gain_d = wr_data;
    else if (win_end && step_now.dn)    gain_d = gain_q - GAIN_W'(1);
    else if (win_end && step_now.up)    gain_d = gain_q + GAIN_W'(1);
    else                                gain_d = gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(GAIN_RST);
      cnt_q  <= '0;
      peak_q <= '0;
    end else begin
      gain_q <= gain_d;
      if (!run) begin
        cnt_q  <= '0;
        peak_q <= '0;
      end else if (smp_valid) begin
        if (win_end) begin
          cnt_q  <= '0;
          peak_q <= '0;
        end else begin
          cnt_q  <= cnt_q + CNT_W'(1);
          peak_q <= peak_now;
        end
      end
    end
  end
endmodule

// File: rtl/vid_gain_ctrl.sv
module vid_gain_ctrl
  import vg_pkg::*;
#(
  parameter int SAMP_W   = 9,
  parameter int GAIN_W   = 12,
  parameter int FRAC_W   = 10,
  parameter int WIN_LEN  = 1024,
  parameter int GAIN_MIN = 256,
  parameter int GAIN_MAX = 4095,
  parameter int HYST     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SAMP_W-1:0] luma_in,
  input  logic [SAMP_W-1:0] chroma_in,
  input  logic              luma_mode,
  input  logic [1:0]        chroma_mode,
  input  logic              freeze,
  input  logic              luma_gain_wr,
  input  logic              chroma_gain_wr,
  input  logic [GAIN_W-1:0] gain_wdata,
  input  logic [SAMP_W-1:0] luma_target,
  input  logic [SAMP_W-1:0] chroma_target,
  output logic              out_valid,
  output logic [SAMP_W-1:0] luma_out,
  output logic [SAMP_W-1:0] chroma_out,
  output logic              luma_clip,
  output logic              chroma_clip,
  output logic [GAIN_W-1:0] luma_gain_rd,
  output logic [GAIN_W-1:0] chroma_gain_rd
);
  localparam int NPATH    = 2;
  localparam int LUMA     = 0;
  localparam int CHROMA   = 1;
  localparam int GAIN_RST = 1 << FRAC_W;

  chroma_mode_e      cmode;
  logic [SAMP_W-1:0] x_in     [NPATH];
  logic [SAMP_W-1:0] tgt      [NPATH];
  logic [SAMP_W-1:0] y_now    [NPATH];
  logic [SAMP_W-1:0] y_q      [NPATH];
  logic [GAIN_W-1:0] g_q      [NPATH];
  logic [GAIN_W-1:0] g_d      [NPATH];
  logic [GAIN_W-1:0] g_act    [NPATH];
  logic [GAIN_W-1:0] fol_val  [NPATH];
  logic [NPATH-1:0]  man, aut, fol, wr, clip_now, clip_q, win_end;
  logic              vld_q;

  // named internal events for the checker
  logic [GAIN_W-1:0] luma_gain_q, chroma_gain_q;
  logic              luma_win_end, chroma_win_end;

  assign cmode = chroma_mode_e'(chroma_mode);

  assign x_in[LUMA]    = luma_in;
  assign x_in[CHROMA]  = chroma_in;
  assign tgt[LUMA]     = luma_target;
  assign tgt[CHROMA]   = chroma_target;
  assign wr[LUMA]      = luma_gain_wr;
  assign wr[CHROMA]    = chroma_gain_wr;

  assign man[LUMA]     = ~luma_mode;
  assign aut[LUMA]     = luma_mode;
  assign fol[LUMA]     = 1'b0;
  assign man[CHROMA]   = (cmode == CM_MANUAL);
  assign aut[CHROMA]   = (cmode == CM_AUTO);
  assign fol[CHROMA]   = (cmode == CM_FOLLOW) || (cmode == CM_FOLLOW2);

  assign fol_val[LUMA]   = '0;
  assign fol_val[CHROMA] = g_d[LUMA];

  // gain acting on this cycle's samples
  assign g_act[LUMA]   = g_q[LUMA];
  assign g_act[CHROMA] = fol[CHROMA] ? g_q[LUMA] : g_q[CHROMA];

  generate
    for (genvar p = 0; p < NPATH; p++) begin : g_path
      vg_mult #(
        .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
      ) u_mult (
        .x(x_in[p]), .g(g_act[p]), .y(y_now[p]), .clip(clip_now[p])
      );

      vg_agc_path #(
        .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .WIN_LEN(WIN_LEN),
        .GAIN_MIN(GAIN_MIN), .GAIN_MAX(GAIN_MAX),
        .GAIN_RST(GAIN_RST), .HYST(HYST)
      ) u_agc (
        .clk(clk), .rst_n(rst_n),
        .manual_en(man[p]), .auto_en(aut[p]), .follow_en(fol[p]),
        .freeze(freeze), .follow_val(fol_val[p]),
        .wr_en(wr[p]), .wr_data(gain_wdata),
        .smp_valid(smp_valid), .y_now(y_now[p]), .target(tgt[p]),
        .gain_q(g_q[p]), .gain_d(g_d[p]), .win_end(win_end[p])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          y_q[p]    <= '0;
          clip_q[p] <= 1'b0;
        end else begin
          clip_q[p] <= smp_valid & clip_now[p];
          if (smp_valid) y_q[p] <= y_now[p];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_valid;
  end

  assign out_valid      = vld_q;
  assign luma_out       = y_q[LUMA];
  assign chroma_out     = y_q[CHROMA];
  assign luma_clip      = clip_q[LUMA];
  assign chroma_clip    = clip_q[CHROMA];
  assign luma_gain_rd   = g_act[LUMA];
  assign chroma_gain_rd = g_act[CHROMA];

  assign luma_gain_q    = g_q[LUMA];
  assign chroma_gain_q  = g_q[CHROMA];
  assign luma_win_end   = win_end[LUMA];
  assign chroma_win_end = win_end[CHROMA];
endmodule

// File: rtl/vg_gain_chk.sv
module vg_gain_chk #(
  parameter int SAMP_W   = 9,
  parameter int GAIN_W   = 12,
  parameter int GAIN_MIN = 256,
  parameter int GAIN_RST = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              luma_mode,
  input logic [1:0]        chroma_mode,
  input logic              freeze,
  input logic              luma_gain_wr,
  input logic [GAIN_W-1:0] gain_wdata,
  input logic [GAIN_W-1:0] luma_gain_rd,
  input logic [SAMP_W-1:0] luma_out,
  input logic [SAMP_W-1:0] chroma_out,
  input logic              luma_clip,
  input logic              chroma_clip,
  input logic [GAIN_W-1:0] luma_gain_q,
  input logic [GAIN_W-1:0] chroma_gain_q,
  input logic              luma_win_end
);
  p_reset_unity_r1: assert property (@(posedge clk)
    !rst_n |=> (luma_gain_q == GAIN_W'(GAIN_RST) && chroma_gain_q == GAIN_W'(GAIN_RST)));

  p_clip_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_clip |-> luma_out == {SAMP_W{1'b1}}) and
    (chroma_clip |-> chroma_out == {SAMP_W{1'b1}}));

  p_manual_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!luma_mode && luma_gain_wr) |=> luma_gain_rd == $past(gain_wdata));

  p_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_mode && !luma_win_end) |=> luma_gain_rd == $past(luma_gain_rd));

  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_mode && luma_gain_rd >= GAIN_W'(GAIN_MIN)) |=> luma_gain_rd >= GAIN_W'(GAIN_MIN));

  p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chroma_mode[1] && $past(chroma_mode[1])) |-> chroma_gain_q == luma_gain_q);

  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_mode && freeze) |=> luma_gain_rd == $past(luma_gain_rd));
endmodule

bind vid_gain_ctrl vg_gain_chk #(
  .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN), .GAIN_RST(GAIN_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .luma_mode(luma_mode), .chroma_mode(chroma_mode),
  .freeze(freeze), .luma_gain_wr(luma_gain_wr), .gain_wdata(gain_wdata),
  .luma_gain_rd(luma_gain_rd), .luma_out(luma_out), .chroma_out(chroma_out),
  .luma_clip(luma_clip), .chroma_clip(chroma_clip),
  .luma_gain_q(luma_gain_q), .chroma_gain_q(chroma_gain_q),
  .luma_win_end(luma_win_end)
);

// File: tb/vid_gain_ctrl_test.sv
module vid_gain_ctrl_test;
  localparam int WIN  = 32;
  localparam int HY   = 16;
  localparam int GMIN = 256;
  localparam int GMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        smp_valid = 0, luma_mode = 0, freeze = 0;
  logic        luma_gain_wr = 0, chroma_gain_wr = 0;
  logic [1:0]  chroma_mode = 0;
  logic [8:0]  luma_in = 0, chroma_in = 0, luma_target = 0, chroma_target = 0;
  logic [11:0] gain_wdata = 0;
  logic        out_valid, luma_clip, chroma_clip;
  logic [8:0]  luma_out, chroma_out;
  logic [11:0] luma_gain_rd, chroma_gain_rd;

  vid_gain_ctrl #(.WIN_LEN(WIN), .HYST(HY)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .luma_in(luma_in), .chroma_in(chroma_in),
    .luma_mode(luma_mode), .chroma_mode(chroma_mode), .freeze(freeze),
    .luma_gain_wr(luma_gain_wr), .chroma_gain_wr(chroma_gain_wr),
    .gain_wdata(gain_wdata), .luma_target(luma_target), .chroma_target(chroma_target),
    .out_valid(out_valid), .luma_out(luma_out), .chroma_out(chroma_out),
    .luma_clip(luma_clip), .chroma_clip(chroma_clip),
    .luma_gain_rd(luma_gain_rd), .chroma_gain_rd(chroma_gain_rd)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0, mdl_on = 0;

  // behavioural reference state
  int mg[2], cnt[2], pk[2], eo[2], ec[2], ev;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loop_step(input int p, input bit au, input bit man, input bit wr,
                           input int y, input int tgt);
    int ng;
    ng = mg[p];
    if (man && wr) ng = int'(gain_wdata);
    if (au && !freeze) begin
      if (smp_valid) begin
        if (y > pk[p]) pk[p] = y;
        if (cnt[p] == WIN - 1) begin
          if (pk[p] > tgt && mg[p] > GMIN) ng = mg[p] - 1;
          else if (pk[p] + HY < tgt && mg[p] < GMAX) ng = mg[p] + 1;
          cnt[p] = 0;
          pk[p]  = 0;
        end else cnt[p]++;
      end
    end else begin
      cnt[p] = 0;
      pk[p]  = 0;
    end
    mg[p] = ng;
  endtask

  always @(posedge clk) begin
    int r0, r1, a0, a1;
    bit fl;
    if (!rst_n) begin
      mg[0] = 1024; mg[1] = 1024;
      cnt[0] = 0; cnt[1] = 0; pk[0] = 0; pk[1] = 0;
      eo[0] = 0; eo[1] = 0; ec[0] = 0; ec[1] = 0; ev = 0;
      mdl_on = 1;
    end else begin
      fl = chroma_mode[1];
      a0 = mg[0];
      a1 = fl ? mg[0] : mg[1];
      r0 = (int'(luma_in) * a0 + 512) >>> 10;
      r1 = (int'(chroma_in) * a1 + 512) >>> 10;
      loop_step(0, luma_mode, !luma_mode, luma_gain_wr, (r0 > 511) ? 511 : r0, int'(luma_target));
      loop_step(1, chroma_mode == 2'b01, chroma_mode == 2'b00, chroma_gain_wr,
                (r1 > 511) ? 511 : r1, int'(chroma_target));
      if (fl) mg[1] = mg[0];
      ev = smp_valid;
      if (smp_valid) begin
        eo[0] = (r0 > 511) ? 511 : r0;
        eo[1] = (r1 > 511) ? 511 : r1;
        ec[0] = (r0 > 511);
        ec[1] = (r1 > 511);
      end else begin
        ec[0] = 0; ec[1] = 0;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (mdl_on && !done) begin
      chk("R2 out_valid", int'(out_valid), ev);
      chk("R2 luma_out", int'(luma_out), eo[0]);
      chk("R2 chroma_out", int'(chroma_out), eo[1]);
      chk("R3 luma_clip", int'(luma_clip), ec[0]);
      chk("R3 chroma_clip", int'(chroma_clip), ec[1]);
      chk("R10 luma_gain_rd", int'(luma_gain_rd), mg[0]);
      chk("R10 chroma_gain_rd", int'(chroma_gain_rd), chroma_mode[1] ? mg[0] : mg[1]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 luma gain", int'(luma_gain_rd), 1024);
    chk("R1 chroma gain", int'(chroma_gain_rd), 1024);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 luma_out", int'(luma_out), 0);
    chk("R1 luma_clip", int'(luma_clip), 0);
    rst_n = 1;

    // manual writes and scaling
    chroma_gain_wr = 1; gain_wdata = 12'h200;
    tick(1); chroma_gain_wr = 0;
    chk("R5 chroma write", int'(chroma_gain_rd), 512);
    chk("R4 luma untouched", int'(luma_gain_rd), 1024);
    luma_gain_wr = 1; gain_wdata = 12'h800;
    tick(1); luma_gain_wr = 0;
    chk("R5 luma write", int'(luma_gain_rd), 2048);
    smp_valid = 1; luma_in = 300; chroma_in = 301;
    tick(1);
    chk("R2 saturated luma", int'(luma_out), 511);
    chk("R3 luma clip", int'(luma_clip), 1);
    chk("R2 half chroma", int'(chroma_out), 151);
    luma_in = 100;
    tick(1);
    chk("R2 doubled luma", int'(luma_out), 200);
    chk("R3 no clip", int'(luma_clip), 0);
    luma_gain_wr = 1; gain_wdata = 12'h400;
    tick(1); luma_gain_wr = 0;

    // automatic rise, write ignored
    luma_in = 200; luma_target = 300; luma_mode = 1;
    luma_gain_wr = 1; gain_wdata = 12'h123;
    tick(1); luma_gain_wr = 0;
    chk("R5 write ignored in auto", int'(luma_gain_rd), 1024);
    tick(95);
    chk("R6 three steps up", int'(luma_gain_rd), 1027);
    chk("R4 chroma untouched", int'(chroma_gain_rd), 512);

    // freeze and restart
    freeze = 1; tick(100);
    chk("R9 frozen", int'(luma_gain_rd), 1027);
    freeze = 0; tick(31);
    chk("R9 fresh window", int'(luma_gain_rd), 1027);
    tick(1);
    chk("R9 step after window", int'(luma_gain_rd), 1028);

    // step down
    luma_in = 500; tick(64);
    chk("R6 two steps down", int'(luma_gain_rd), 1026);

    // mode changes keep value
    luma_mode = 0; tick(1);
    chk("R11 auto to manual", int'(luma_gain_rd), 1026);
    luma_gain_wr = 1; gain_wdata = 12'h300;
    tick(1); luma_gain_wr = 0;
    chk("R5 manual write", int'(luma_gain_rd), 768);
    luma_in = 200; luma_mode = 1; tick(1);
    chk("R11 manual to auto", int'(luma_gain_rd), 768);

    // limits
    luma_mode = 0; luma_gain_wr = 1; gain_wdata = 12'h100;
    tick(1); luma_gain_wr = 0;
    luma_in = 511; luma_target = 100; luma_mode = 1;
    tick(64);
    chk("R7 floor", int'(luma_gain_rd), 256);
    luma_mode = 0; luma_gain_wr = 1; gain_wdata = 12'hFFF;
    tick(1); luma_gain_wr = 0;
    luma_in = 10; luma_target = 400; luma_mode = 1;
    tick(64);
    chk("R7 ceiling", int'(luma_gain_rd), 4095);

    // follow mode
    luma_mode = 0; luma_gain_wr = 1; gain_wdata = 12'h500;
    tick(1); luma_gain_wr = 0;
    chroma_mode = 2'b10; tick(1);
    chk("R8 follow readback", int'(chroma_gain_rd), 1280);
    chroma_in = 100; tick(2);
    chk("R8 follow scaling", int'(chroma_out), 125);
    chroma_mode = 2'b00; tick(1);
    chk("R8 kept after follow", int'(chroma_gain_rd), 1280);
    chroma_mode = 2'b01; chroma_in = 50; chroma_target = 200;
    tick(32);
    chk("R6 chroma step up", int'(chroma_gain_rd), 1281);

    // random collisions of window ends with control events
    for (int i = 0; i < 3000; i++) begin
      smp_valid = ($urandom % 4) != 0;
      luma_in   = 9'($urandom);
      chroma_in = 9'($urandom);
      luma_gain_wr   = ($urandom % 40) == 0;
      chroma_gain_wr = ($urandom % 40) == 0;
      gain_wdata = 12'($urandom % 1500 + 200);
      if (($urandom % 60) == 0) freeze = ~freeze;
      if (($urandom % 50) == 0) begin
        luma_mode     = 1'($urandom);
        chroma_mode   = 2'($urandom);
        luma_target   = 9'($urandom);
        chroma_target = 9'($urandom);
      end
      tick(1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule